// File: doc/BRIEF.md
# Functional Unit Occupancy and Result-Timing Scoreboard

This block sits at the issue stage of an out-of-order-free, in-order issue pipeline and decides, one operation per cycle, whether an operation may leave for its execution unit. It keeps a down-counter for each of eight execution units (two integer, two load/store, two floating-point, one branch, one condition-register unit) and two down-counters for each destination register. One gives the cycle at which ordinary consumers may read the result. The other gives the later cycle at which branch and condition-register consumers may read it.

An operation is granted when its unit is idle and all of its enabled sources are ready for that kind of consumer. On a grant, the unit counter is loaded with the operation's occupancy minus one, so fully pipelined classes can issue back to back. Long operations such as divide and square root hold their unit for tens of cycles. The destination counters are loaded with the class latency minus one. A recording compare writes a longer count into the branch/CR counter than into the ordinary one. Decode, grouping and the arithmetic itself live elsewhere.

Top module: `fu_scoreboard`

## Requirements
- R1: After reset, `unit_busy` is all zeros and `reg_ready` and `reg_cr_ready` are all ones.
- R2: `grant` is high in a cycle exactly when `req_valid` is high, the target unit is idle, and each enabled source is ready. Branch and CR classes (13, 14, 15) test `reg_cr_ready`; all other classes test `reg_ready`.
- R3: Unit indices are 0/1 integer, 2/3 load/store, 4/5 floating-point, 6 branch, 7 CR. Classes 0-4 go to integer unit `req_side`, 7-8 to load/store unit 2+`req_side`, 9-12 to FP unit 4+`req_side`, class 13 to unit 6, and classes 14-15 to unit 7.
- R4: Divide classes 5 and 6 always occupy integer unit 1, whatever `req_side` is.
- R5: A grant keeps its unit busy so that the next grant on that unit comes at the earliest H cycles later. H is 4 for class 3, 6 for class 4, 35 for class 5, 67 for class 6, 28 for class 11, 35 for class 12, and 1 (back to back) for every other class.
- R6: A grant with `req_dst_en` makes the destination not ready, so that an ordinary consumer is granted at the earliest L cycles later. L by class is: 0 int=2, 1 int compare=3, 2 recording compare=2, 3=5, 4=7, 5=36, 6=68, 7 load=4, 8 FP load=6, 9 FP op=6, 10 FP compare=5, 11=33, 12=40, 13 branch=2, 14 CR logical=2, 15 CR move=3.
- R7: For class 2, `reg_cr_ready` stays low for 4 cycles, while `reg_ready` for the same register becomes ready after 2. For every other class, both flags track L. `reg_cr_ready` is never high while `reg_ready` is low.
- R8: A request that is not granted changes no unit counter and no register counter.
- R9: A granted operation with `req_dst_en` low leaves every register flag untouched.
- R10: Every counter decrements by one per cycle until it reaches zero, and then stays at zero until it is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | An operation asks to issue this cycle |
| req_class | input | 4 | Operation class code (see R3, R5, R6) |
| req_side | input | 1 | Chooses unit 0 or 1 of a unit pair |
| req_src_a_en | input | 1 | Source A is used |
| req_src_a | input | RW | Source A register index |
| req_src_b_en | input | 1 | Source B is used |
| req_src_b | input | RW | Source B register index |
| req_dst_en | input | 1 | Operation writes a register |
| req_dst | input | RW | Destination register index |
| grant | output | 1 | Operation is accepted this cycle |
| unit_busy | output | 8 | One bit per unit, high while occupied |
| reg_ready | output | NREG | Result visible to ordinary consumers |
| reg_cr_ready | output | NREG | Result visible to branch and CR consumers |

## Verification
The bench goes after the long occupancy windows: a divide requested on side 0 must still block integer unit 1 for 35 or 67 cycles. A design that routed by `req_side` would instead free the wrong unit. The recording compare is tested with ordinary, branch, CR-logical and CR-move consumers. Mixing up the two counters would grant the CR consumer after 2 cycles instead of 4. Denied requests that carry a destination are checked for leaving the register ready, which catches a design that loads counters from the request rather than from the grant. A long random stream compared every cycle against a behavioural model covers pipelined back-to-back issue and counters that saturate at zero.

// File: rtl/fus_pkg.sv
package fus_pkg;

  localparam int N_UNITS = 8;
  localparam int CNT_W   = 7;
  localparam int CLS_W   = 4;

  localparam int U_IU_BASE = 0;
  localparam int U_LS_BASE = 2;
  localparam int U_FP_BASE = 4;
  localparam int U_BRANCH  = 6;
  localparam int U_CRUNIT  = 7;

  typedef enum logic [CLS_W-1:0] {
    OC_INT   = 4'd0,
    OC_ICMP  = 4'd1,
    OC_RCMP  = 4'd2,
    OC_MUL32 = 4'd3,
    OC_MUL64 = 4'd4,
    OC_DIV32 = 4'd5,
    OC_DIV64 = 4'd6,
    OC_LD    = 4'd7,
    OC_FPLD  = 4'd8,
    OC_FPOP  = 4'd9,
    OC_FCMP  = 4'd10,
    OC_FDIV  = 4'd11,
    OC_FSQRT = 4'd12,
    OC_BR    = 4'd13,
    OC_CRL   = 4'd14,
    OC_CRMV  = 4'd15
  } op_class_e;

  typedef enum logic [2:0] {
    G_INT_PAIR,
    G_LS_PAIR,
    G_FP_PAIR,
    G_IU_HIGH,
    G_BRANCH,
    G_CR
  } unit_grp_e;

  typedef struct packed {
    unit_grp_e        grp;
    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] lat;
    logic [CNT_W-1:0] lat_cr;
  } cls_info_t;

  function automatic cls_info_t class_info(op_class_e c);
    cls_info_t r;
    r.grp = G_INT_PAIR;
    r.occ = CNT_W'(1);
    r.lat = CNT_W'(2);
    unique case (c)
      OC_INT:   r.lat = CNT_W'(2);
      OC_ICMP:  r.lat = CNT_W'(3);
      OC_RCMP:  r.lat = CNT_W'(2);
      OC_MUL32: begin r.occ = CNT_W'(4);  r.lat = CNT_W'(5);  end
      OC_MUL64: begin r.occ = CNT_W'(6);  r.lat = CNT_W'(7);  end
      OC_DIV32: begin r.grp = G_IU_HIGH; r.occ = CNT_W'(35); r.lat = CNT_W'(36); end
      OC_DIV64: begin r.grp = G_IU_HIGH; r.occ = CNT_W'(67); r.lat = CNT_W'(68); end
      OC_LD:    begin r.grp = G_LS_PAIR; r.lat = CNT_W'(4); end
      OC_FPLD:  begin r.grp = G_LS_PAIR; r.lat = CNT_W'(6); end
      OC_FPOP:  begin r.grp = G_FP_PAIR; r.lat = CNT_W'(6); end
      OC_FCMP:  begin r.grp = G_FP_PAIR; r.lat = CNT_W'(5); end
      OC_FDIV:  begin r.grp = G_FP_PAIR; r.occ = CNT_W'(28); r.lat = CNT_W'(33); end
      OC_FSQRT: begin r.grp = G_FP_PAIR; r.occ = CNT_W'(35); r.lat = CNT_W'(40); end
      OC_BR:    begin r.grp = G_BRANCH;  r.lat = CNT_W'(2); end
      OC_CRL:   begin r.grp = G_CR;      r.lat = CNT_W'(2); end
      OC_CRMV:  begin r.grp = G_CR;      r.lat = CNT_W'(3); end
      default:  r.lat = CNT_W'(2);
    endcase
    r.lat_cr = (c == OC_RCMP) ? CNT_W'(4) : r.lat;
    return r;
  endfunction

endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/sb_countdown.sv
module sb_countdown #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ld | (cnt_q != '0);
    cnt_d  = ld ? ld_val : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  // R10: a running counter steps down by exactly one
  assert_countdown_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R10: an idle counter rests at zero until reloaded
  assert_rest_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sb_route.sv
module sb_route
  import fus_pkg::*;
(
  input  op_class_e          cls,
  input  logic               side,
  output logic [N_UNITS-1:0] tgt,
  output logic               late_cons,
  output logic [CNT_W-1:0]   occ_m1,
  output logic [CNT_W-1:0]   lat_m1,
  output logic [CNT_W-1:0]   lat_cr_m1
);

  cls_info_t info;
  int        idx;

  always_comb begin
    info = class_info(cls);
    unique case (info.grp)
      G_INT_PAIR: idx = U_IU_BASE + int'(side);
      G_LS_PAIR:  idx = U_LS_BASE + int'(side);
      G_FP_PAIR:  idx = U_FP_BASE + int'(side);
      G_IU_HIGH:  idx = U_IU_BASE + 1;
      G_BRANCH:   idx = U_BRANCH;
      default:    idx = U_CRUNIT;
    endcase
    tgt = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      if (u == idx) tgt[u] = 1'b1;
    end
    late_cons = (cls == OC_BR) || (cls == OC_CRL) || (cls == OC_CRMV);
    occ_m1    = info.occ    - CNT_W'(1);
    lat_m1    = info.lat    - CNT_W'(1);
    lat_cr_m1 = info.lat_cr - CNT_W'(1);
  end

endmodule

// File: rtl/fu_scoreboard.sv
module fu_scoreboard
  import fus_pkg::*;
#(
  parameter  int NREG = 8,
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CLS_W-1:0]   req_class,
  input  logic               req_side,
  input  logic               req_src_a_en,
  input  logic [RW-1:0]      req_src_a,
  input  logic               req_src_b_en,
  input  logic [RW-1:0]      req_src_b,
  input  logic               req_dst_en,
  input  logic [RW-1:0]      req_dst,
  output logic               grant,
  output logic [N_UNITS-1:0] unit_busy,
  output logic [NREG-1:0]    reg_ready,
  output logic [NREG-1:0]    reg_cr_ready
);

  logic               rst_core_n;
  op_class_e          cls;
  logic [N_UNITS-1:0] tgt;
  logic               late_cons;
  logic [CNT_W-1:0]   occ_m1;
  logic [CNT_W-1:0]   lat_m1;
  logic [CNT_W-1:0]   lat_cr_m1;
  logic [N_UNITS-1:0] unit_idle;
  logic               unit_ok;
  logic               src_a_ok;
  logic               src_b_ok;

  sb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  assign cls = op_class_e'(req_class);

  sb_route i_route (
    .cls       (cls),
    .side      (req_side),
    .tgt       (tgt),
    .late_cons (late_cons),
    .occ_m1    (occ_m1),
    .lat_m1    (lat_m1),
    .lat_cr_m1 (lat_cr_m1)
  );

  always_comb begin
    unit_ok  = |(tgt & unit_idle);
    src_a_ok = !req_src_a_en ||
               (late_cons ? reg_cr_ready[req_src_a] : reg_ready[req_src_a]);
    src_b_ok = !req_src_b_en ||
               (late_cons ? reg_cr_ready[req_src_b] : reg_ready[req_src_b]);
    grant    = req_valid && unit_ok && src_a_ok && src_b_ok;
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    sb_countdown #(.CW(CNT_W)) i_occ (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .ld     (grant && tgt[u]),
      .ld_val (occ_m1),
      .zero   (unit_idle[u])
    );
    assign unit_busy[u] = !unit_idle[u];
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic dst_hit;
    assign dst_hit = grant && req_dst_en && (req_dst == RW'(r));

    sb_countdown #(.CW(CNT_W)) i_norm (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .ld     (dst_hit),
      .ld_val (lat_m1),
      .zero   (reg_ready[r])
    );

    sb_countdown #(.CW(CNT_W)) i_late (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .ld     (dst_hit),
      .ld_val (lat_cr_m1),
      .zero   (reg_cr_ready[r])
    );
  end

  // R2: a granted source was ready for its consumer kind
  assert_grant_src_ready_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (grant && req_src_a_en) |->
      (late_cons ? reg_cr_ready[req_src_a] : reg_ready[req_src_a]));

  // R4: any granted divide leaves integer unit 1 occupied
  assert_div_on_high_iu_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (grant && (req_class == OC_DIV32 || req_class == OC_DIV64)) |=> unit_busy[1]);

  // R5: a multi-cycle multiply on integer unit 0 occupies it next cycle
  assert_mul_occupies_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (grant && req_class == OC_MUL32 && !req_side) |=> unit_busy[0]);

  // R7: branch/CR visibility never precedes ordinary visibility
  assert_cr_after_norm_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_cr_ready & ~reg_ready) == '0);

  // R8: a request to an occupied branch unit is refused
  assert_no_grant_busy_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_class == OC_BR && unit_busy[U_BRANCH]) |-> !grant);

endmodule

// File: tb/test_fu_scoreboard.sv
`timescale 1ns/1ps
module test_fu_scoreboard;

  localparam int NREG = 8;
  localparam int RW   = 3;
  localparam int NU   = 8;

  localparam int OCC [16] = '{1, 1, 1, 4, 6, 35, 67, 1, 1, 1, 1, 28, 35, 1, 1, 1};
  localparam int LAT [16] = '{2, 3, 2, 5, 7, 36, 68, 4, 6, 6, 5, 33, 40, 2, 2, 3};

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic [3:0]      req_class;
  logic            req_side;
  logic            req_src_a_en;
  logic [RW-1:0]   req_src_a;
  logic            req_src_b_en;
  logic [RW-1:0]   req_src_b;
  logic            req_dst_en;
  logic [RW-1:0]   req_dst;
  logic            grant;
  logic [NU-1:0]   unit_busy;
  logic [NREG-1:0] reg_ready;
  logic [NREG-1:0] reg_cr_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_busy [NU];
  int m_rdy  [NREG];
  int m_late [NREG];

  always #5 clk = ~clk;

  fu_scoreboard #(.NREG(NREG)) i_fu_scoreboard (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_class    (req_class),
    .req_side     (req_side),
    .req_src_a_en (req_src_a_en),
    .req_src_a    (req_src_a),
    .req_src_b_en (req_src_b_en),
    .req_src_b    (req_src_b),
    .req_dst_en   (req_dst_en),
    .req_dst      (req_dst),
    .grant        (grant),
    .unit_busy    (unit_busy),
    .reg_ready    (reg_ready),
    .reg_cr_ready (reg_cr_ready)
  );

  function automatic int unit_of(int c, int s);
    if (c == 5 || c == 6) return 1;
    if (c <= 4)  return s;
    if (c <= 8)  return 2 + s;
    if (c <= 12) return 4 + s;
    if (c == 13) return 6;
    return 7;
  endfunction

  function automatic int late_lat(int c);
    return (c == 2) ? 4 : LAT[c];
  endfunction

  task automatic chk(input string tag, input bit ok, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_grant();
    int  c;
    bit  lc;
    bit  g;
    c  = int'(req_class);
    lc = (c >= 13);
    g  = req_valid && (m_busy[unit_of(c, int'(req_side))] == 0);
    if (req_src_a_en) g = g && ((lc ? m_late[req_src_a] : m_rdy[req_src_a]) == 0);
    if (req_src_b_en) g = g && ((lc ? m_late[req_src_b] : m_rdy[req_src_b]) == 0);
    return g;
  endfunction

  task automatic step(input string tag, output bit g);
    logic [NU-1:0]   eb;
    logic [NREG-1:0] er;
    logic [NREG-1:0] el;
    int c;
    @(negedge clk);
    g = model_grant();
    for (int u = 0; u < NU; u++) eb[u] = (m_busy[u] != 0);
    for (int r = 0; r < NREG; r++) begin
      er[r] = (m_rdy[r] == 0);
      el[r] = (m_late[r] == 0);
    end
    chk(tag, grant === g, "grant", longint'(grant), longint'(g));
    chk(tag, unit_busy === eb, "unit_busy", longint'(unit_busy), longint'(eb));
    chk(tag, reg_ready === er, "reg_ready", longint'(reg_ready), longint'(er));
    chk(tag, reg_cr_ready === el, "reg_cr_ready", longint'(reg_cr_ready), longint'(el));
    @(posedge clk);
    for (int u = 0; u < NU; u++) if (m_busy[u] > 0) m_busy[u]--;
    for (int r = 0; r < NREG; r++) begin
      if (m_rdy[r] > 0)  m_rdy[r]--;
      if (m_late[r] > 0) m_late[r]--;
    end
    if (g && rst_n) begin
      c = int'(req_class);
      m_busy[unit_of(c, int'(req_side))] = OCC[c] - 1;
      if (req_dst_en) begin
        m_rdy[req_dst]  = LAT[c] - 1;
        m_late[req_dst] = late_lat(c) - 1;
      end
    end
    #1;
  endtask

  task automatic drive(input int c, input int s, input bit ae, input int a,
                       input bit be, input int b, input bit de, input int d);
    req_valid    = 1'b1;
    req_class    = 4'(c);
    req_side     = s[0];
    req_src_a_en = ae;
    req_src_a    = RW'(a);
    req_src_b_en = be;
    req_src_b    = RW'(b);
    req_dst_en   = de;
    req_dst      = RW'(d);
  endtask

  task automatic idle(input int n);
    bit g;
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) step("R10", g);
  endtask

  task automatic issue_once(input string tag, input int c, input int s, input bit de, input int d);
    bit g;
    drive(c, s, 1'b0, 0, 1'b0, 0, de, d);
    step(tag, g);
    chk(tag, g, "producer grant", longint'(g), 1);
    req_valid = 1'b0;
  endtask

  task automatic try_until(input string tag, output int n);
    bit g;
    n = 0;
    g = 1'b0;
    while (!g && n < 100) begin
      step(tag, g);
      n++;
    end
    req_valid = 1'b0;
  endtask

  task automatic probe(input string tag, input int c, input int s, input bit ae,
                       input int a, input int exp_n);
    int n;
    drive(c, s, ae, a, 1'b0, 0, 1'b0, 0);
    try_until(tag, n);
    chk(tag, n == exp_n, "cycles to grant", longint'(n), longint'(exp_n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g;
    for (int u = 0; u < NU; u++) m_busy[u] = 0;
    for (int r = 0; r < NREG; r++) begin m_rdy[r] = 0; m_late[r] = 0; end
    req_valid = 1'b0; req_class = '0; req_side = 1'b0;
    req_src_a_en = 1'b0; req_src_a = '0; req_src_b_en = 1'b0; req_src_b = '0;
    req_dst_en = 1'b0; req_dst = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    chk("R1", unit_busy == '0, "busy after reset", longint'(unit_busy), 0);
    chk("R1", reg_ready == '1 && reg_cr_ready == '1, "ready after reset",
        longint'({reg_ready, reg_cr_ready}), 16'hffff);

    // R5: multiply occupancy, and R3 pair independence
    issue_once("R5", 3, 0, 1'b0, 0);
    probe("R5", 0, 0, 1'b0, 0, 4);
    issue_once("R5", 4, 1, 1'b0, 0);
    probe("R3", 0, 0, 1'b0, 0, 1);
    probe("R5", 0, 1, 1'b0, 0, 5);
    idle(8);
    // R5: pipelined back to back
    issue_once("R5", 0, 0, 1'b0, 0);
    probe("R5", 0, 0, 1'b0, 0, 1);
    idle(4);

    // R4: divide on side 0 lands on integer unit 1
    issue_once("R4", 5, 0, 1'b0, 0);
    probe("R4", 0, 0, 1'b0, 0, 1);
    probe("R4", 0, 1, 1'b0, 0, 34);
    idle(4);
    issue_once("R4", 6, 0, 1'b0, 0);
    probe("R4", 0, 1, 1'b0, 0, 67);
    idle(4);

    // R6: latencies seen by ordinary consumers
    issue_once("R6", 0, 0, 1'b1, 1);
    probe("R6", 0, 1, 1'b1, 1, 2);
    issue_once("R6", 7, 0, 1'b1, 2);
    probe("R6", 0, 0, 1'b1, 2, 4);
    issue_once("R6", 8, 1, 1'b1, 3);
    probe("R6", 9, 0, 1'b1, 3, 6);
    issue_once("R6", 9, 0, 1'b1, 4);
    probe("R6", 10, 1, 1'b1, 4, 6);
    issue_once("R6", 10, 1, 1'b1, 5);
    probe("R6", 0, 0, 1'b1, 5, 5);
    issue_once("R6", 1, 0, 1'b1, 6);
    probe("R6", 13, 0, 1'b1, 6, 3);
    idle(4);

    // R5: FP divide and square root occupancy
    issue_once("R5", 11, 0, 1'b0, 0);
    probe("R5", 9, 0, 1'b0, 0, 28);
    issue_once("R5", 12, 1, 1'b0, 0);
    probe("R5", 9, 1, 1'b0, 0, 35);
    idle(4);

    // R7: recording compare, ordinary vs branch/CR consumers
    issue_once("R7", 2, 0, 1'b1, 7);
    probe("R7", 0, 1, 1'b1, 7, 2);
    issue_once("R7", 2, 0, 1'b1, 7);
    probe("R7", 14, 0, 1'b1, 7, 4);
    issue_once("R7", 2, 1, 1'b1, 7);
    probe("R7", 13, 0, 1'b1, 7, 4);
    issue_once("R7", 2, 0, 1'b1, 7);
    probe("R7", 15, 0, 1'b1, 7, 4);
    idle(6);

    // R3: branch and CR units are pipelined and separate
    issue_once("R3", 13, 0, 1'b0, 0);
    probe("R3", 13, 1, 1'b0, 0, 1);
    issue_once("R3", 14, 0, 1'b0, 0);
    probe("R3", 15, 0, 1'b0, 0, 1);
    idle(4);

    // R8: refused request with destination touches nothing
    issue_once("R8", 4, 0, 1'b0, 0);
    drive(0, 0, 1'b0, 0, 1'b0, 0, 1'b1, 1);
    step("R8", g);
    req_valid = 1'b0;
    chk("R8", !g && reg_ready[1] && reg_cr_ready[1], "refused dest untouched",
        longint'({g, reg_ready[1], reg_cr_ready[1]}), 3);
    idle(8);

    // R9: granted op without destination leaves registers alone
    drive(0, 1, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    step("R9", g);
    req_valid = 1'b0;
    chk("R9", g && reg_ready == '1 && reg_cr_ready == '1, "no-dest grant",
        longint'({reg_ready, reg_cr_ready}), 16'hffff);

    // R2: random stream against the model
    for (int i = 0; i < 3000; i++) begin
      drive(int'($urandom_range(0, 15)), int'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
      req_valid = 1'($urandom_range(0, 3) != 0);
      step("R2", g);
    end
    idle(80);
    // R10: everything drains to zero and rests there
    chk("R10", unit_busy == '0 && reg_ready == '1, "drained",
        longint'({unit_busy, reg_ready}), 16'h00ff);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule